// File: doc/BRIEF.md
# Dual-Port Eligible Warp Issue Scheduler

This block picks, every clock cycle, up to two warps to issue from a pool of resident warp slots. Each slot presents a valid bit, a stall flag and the class of its next instruction. A slot is selectable only when it is valid, not stalled, carries a real class and the unit for that class can take work. The stall flag covers barrier, memory and dependency stalls. Port 0 serves the even slots and port 1 the odd slots. Each port has its own round-robin pointer. The two ports ignore which thread block a warp belongs to.

There is one execution unit per class. A unit narrower than a warp takes several back-to-back passes per instruction, and it stays occupied for those passes. A request whose unit is occupied is not dropped. It stays pending until the unit frees up. The upstream logic owns the slot state. A grant tells it that the slot's instruction has been accepted, and the upstream logic then updates or clears the slot.

Top module: `wis_issue_sched`

## Requirements
- R1: After reset, `unit_busy` is 0 and no grant is given while no slot is eligible. The first search of port 0 starts at slot 0 and the first search of port 1 starts at slot 1. The reset input deasserts through a two-stage synchronizer.
- R2: A slot is eligible only when all of the following hold: its valid bit is 1, its stall bit is 0, its class code is not 3 and its class unit is not busy. Slot w's class code is `slot_cls[2w+1:2w]`, with 0 = ALU, 1 = load/store, 2 = special function and 3 = no instruction.
- R3: Port 0 grants only even slot IDs and port 1 grants only odd slot IDs, so one warp never takes both ports in a cycle. Bit 0 of `gnt_vld` belongs to port 0 and bit 1 to port 1.
- R4: Each port searches its own slots in round-robin order. After granting its local slot k (global ID 2k+port), the next search starts at local slot k+1 and wraps past the last slot to slot 0.
- R5: A port with no eligible slot drives its `gnt_vld` bit low and its ID output to 0, and its pointer keeps its value.
- R6: A unit accepts at most one instruction per cycle. Port 0 has priority. While port 0 grants a class, odd slots of that same class are not eligible for port 1 in that cycle, and port 1 picks the next eligible odd slot of another class in its round-robin order.
- R7: The passes per instruction are 32 divided by the unit's lane count: ALU has 32 lanes (1 pass), load/store has 16 lanes (2 passes) and special function has 8 lanes (4 passes). A grant of a class in cycle t holds that class's `unit_busy` bit at 1 for cycles t+1 to t+passes-1. `unit_busy` bit 0 is ALU, bit 1 is load/store and bit 2 is special function.
- R8: A request for a busy unit stays pending and is granted in the first cycle the unit is free, if the round-robin order allows it. This includes a new special-function request that arrives during a four-pass issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_valid | input | NUM_WARPS | Slot holds a resident warp |
| slot_stall | input | NUM_WARPS | Slot is stalled (barrier, memory or dependency) |
| slot_cls | input | 2*NUM_WARPS | Class code of each slot's next instruction |
| gnt_vld | output | 2 | Grant valid, one bit per port |
| gnt_id0 | output | IDW | Slot granted on port 0 (even) |
| gnt_id1 | output | IDW | Slot granted on port 1 (odd) |
| unit_busy | output | 3 | Unit occupied by remaining passes, one bit per class |

## Verification
The bench drives the four-pass special-function case with requests arriving during the busy window. A design that miscounts passes would either grant into an occupied unit or leave a free unit idle for a cycle. It sets both ports on the same class, where a design without the port-0 priority filter would hand two warps to one unit. It runs an idle stretch followed by a sparse pool, which exposes a pointer that advances without a grant. It also uses a two-slot pool that wraps past the last slot. Stalled slots and class code 3 are mixed into full pools to catch an eligibility filter that lets either of them through.

// File: rtl/wis_pkg.sv
package wis_pkg;

  typedef enum logic [1:0] {
    CLS_ALU  = 2'd0,
    CLS_LSU  = 2'd1,
    CLS_SFU  = 2'd2,
    CLS_NONE = 2'd3
  } wcls_e;

  localparam int NCLS = 3;

  function automatic int pass_count(input int warp_w, input int lanes);
    return (lanes >= warp_w) ? 1 : (warp_w / lanes);
  endfunction

endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int N  = 24,
  localparam int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] last,
  output logic          vld,
  output logic [LW-1:0] idx
);

  // Search from last+1 upward with wrap; the nearest hit wins.
  always_comb begin
    vld = 1'b0;
    idx = '0;
    for (int k = N; k >= 1; k--) begin
      int c;
      c = int'(last) + k;
      if (c >= N) c = c - N;
      if (req[c]) begin
        vld = 1'b1;
        idx = LW'(c);
      end
    end
  end

endmodule

// File: rtl/wis_unit_track.sv
module wis_unit_track
  import wis_pkg::*;
#(
  parameter int WARP_W  = 32,
  parameter int ALU_LN  = 32,
  parameter int LSU_LN  = 16,
  parameter int SFU_LN  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] hit,
  output logic [NCLS-1:0] busy
);

  for (genvar c = 0; c < NCLS; c++) begin : g_unit
    localparam int P  = (c == 0) ? pass_count(WARP_W, ALU_LN) :
                        (c == 1) ? pass_count(WARP_W, LSU_LN) :
                                   pass_count(WARP_W, SFU_LN);
    localparam int CW = (P > 1) ? $clog2(P) : 1;

    logic [CW-1:0] cnt_q, cnt_d;
    logic          cnt_en;

    always_comb begin
      cnt_en = 1'b0;
      cnt_d  = cnt_q;
      if (hit[c]) begin
        cnt_en = 1'b1;
        cnt_d  = CW'(P - 1);
      end else if (cnt_q != '0) begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign busy[c] = (cnt_q != '0);
  end

endmodule

// File: rtl/wis_issue_sched.sv
module wis_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 48,
  parameter int WARP_W    = 32,
  parameter int ALU_LN    = 32,
  parameter int LSU_LN    = 16,
  parameter int SFU_LN    = 8,
  localparam int IDW      = $clog2(NUM_WARPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_WARPS-1:0]   slot_valid,
  input  logic [NUM_WARPS-1:0]   slot_stall,
  input  logic [2*NUM_WARPS-1:0] slot_cls,
  output logic [1:0]             gnt_vld,
  output logic [IDW-1:0]         gnt_id0,
  output logic [IDW-1:0]         gnt_id1,
  output logic [NCLS-1:0]        unit_busy
);

  localparam int HALF = NUM_WARPS / 2;
  localparam int LW   = (HALF > 1) ? $clog2(HALF) : 1;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // Unit occupancy
  logic [NCLS-1:0] busy;
  logic [NCLS-1:0] hit;
  logic [3:0]      busy_ext;

  assign busy_ext = {1'b1, busy};   // code 3 never has a free unit

  // Base eligibility per slot
  logic [NUM_WARPS-1:0] base;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    assign base[w] = slot_valid[w] & ~slot_stall[w] & ~busy_ext[slot_cls[2*w +: 2]];
  end

  // Port 0: even slots
  logic [HALF-1:0] req_e, req_o;
  logic [LW-1:0]   ptr0_q, ptr0_d, ptr1_q, ptr1_d;
  logic [LW-1:0]   loc0, loc1;
  logic            vld0, vld1;
  logic            ptr0_en, ptr1_en;
  logic [IDW-1:0]  id0, id1;
  logic [1:0]      cls0, cls1;

  for (genvar j = 0; j < HALF; j++) begin : g_even
    assign req_e[j] = base[2*j];
  end

  wis_rr_pick #(.N(HALF)) u_pick0 (
    .req  (req_e),
    .last (ptr0_q),
    .vld  (vld0),
    .idx  (loc0)
  );

  assign id0  = IDW'({loc0, 1'b0});
  assign cls0 = slot_cls[2*id0 +: 2];

  // Port 1: odd slots, masked by the class port 0 takes
  for (genvar j = 0; j < HALF; j++) begin : g_odd
    assign req_o[j] = base[2*j+1] &
                      ~(vld0 && (slot_cls[2*(2*j+1) +: 2] == cls0));
  end

  wis_rr_pick #(.N(HALF)) u_pick1 (
    .req  (req_o),
    .last (ptr1_q),
    .vld  (vld1),
    .idx  (loc1)
  );

  assign id1  = IDW'({loc1, 1'b1});
  assign cls1 = slot_cls[2*id1 +: 2];

  // Units hit this cycle
  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      hit[c] = (vld0 && (int'(cls0) == c)) || (vld1 && (int'(cls1) == c));
    end
  end

  wis_unit_track #(
    .WARP_W (WARP_W),
    .ALU_LN (ALU_LN),
    .LSU_LN (LSU_LN),
    .SFU_LN (SFU_LN)
  ) u_track (
    .clk   (clk),
    .rst_n (rst_i_n),
    .hit   (hit),
    .busy  (busy)
  );

  // Pointer next state
  always_comb begin
    ptr0_en = vld0;
    ptr0_d  = loc0;
    ptr1_en = vld1;
    ptr1_d  = loc1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ptr0_q <= LW'(HALF - 1);
      ptr1_q <= LW'(HALF - 1);
    end else begin
      if (ptr0_en) ptr0_q <= ptr0_d;
      if (ptr1_en) ptr1_q <= ptr1_d;
    end
  end

  assign gnt_vld   = {vld1, vld0};
  assign gnt_id0   = vld0 ? id0 : '0;
  assign gnt_id1   = vld1 ? id1 : '0;
  assign unit_busy = busy;

endmodule

// File: rtl/wis_issue_chk.sv
module wis_issue_chk #(
  parameter int NUM_WARPS = 48,
  parameter int IDW       = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_WARPS-1:0]   slot_valid,
  input logic [NUM_WARPS-1:0]   slot_stall,
  input logic [2*NUM_WARPS-1:0] slot_cls,
  input logic [1:0]             gnt_vld,
  input logic [IDW-1:0]         gnt_id0,
  input logic [IDW-1:0]         gnt_id1,
  input logic [2:0]             unit_busy
);

  logic [1:0] c0, c1;
  logic [3:0] bz;
  logic       sfu_go, lsu_go;

  assign c0     = slot_cls[2*gnt_id0 +: 2];
  assign c1     = slot_cls[2*gnt_id1 +: 2];
  assign bz     = {1'b1, unit_busy};
  assign sfu_go = (gnt_vld[0] && c0 == 2'd2) || (gnt_vld[1] && c1 == 2'd2);
  assign lsu_go = (gnt_vld[0] && c0 == 2'd1) || (gnt_vld[1] && c1 == 2'd1);

  a_r2_port0_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[0] |-> slot_valid[gnt_id0] && !slot_stall[gnt_id0] && c0 != 2'd3);

  a_r2_port1_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[1] |-> slot_valid[gnt_id1] && !slot_stall[gnt_id1] && c1 != 2'd3);

  a_r3_even_port0: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[0] |-> !gnt_id0[0]);

  a_r3_odd_port1: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[1] |-> gnt_id1[0]);

  a_r6_one_per_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (&gnt_vld) |-> c0 != c1);

  a_r8_no_issue_busy0: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[0] |-> !bz[c0]);

  a_r8_no_issue_busy1: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld[1] |-> !bz[c1]);

  a_r7_sfu_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    sfu_go |=> unit_busy[2]);

  a_r7_lsu_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    lsu_go |=> unit_busy[1]);

  a_r7_alu_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_busy[0]);

endmodule

bind wis_issue_sched wis_issue_chk #(
  .NUM_WARPS (NUM_WARPS),
  .IDW       (IDW)
) u_chk (.*);

// File: tb/sim_wis_issue_sched.sv
module sim_wis_issue_sched;

  localparam int NW  = 48;
  localparam int H   = NW / 2;
  localparam int IDW = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NW-1:0]   sv, ss;
  logic [2*NW-1:0] sc;
  logic [1:0]      gnt_vld;
  logic [IDW-1:0]  gnt_id0, gnt_id1;
  logic [2:0]      unit_busy;

  always #10 clk = ~clk;

  wis_issue_sched u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_valid (sv),
    .slot_stall (ss),
    .slot_cls   (sc),
    .gnt_vld    (gnt_vld),
    .gnt_id0    (gnt_id0),
    .gnt_id1    (gnt_id1),
    .unit_busy  (unit_busy)
  );

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [1:0]     vld;
    logic [IDW-1:0] id0;
    logic [IDW-1:0] id1;
    logic [2:0]     busy;
    string          tag;
  } exp_t;

  exp_t q[$];

  int mptr[2];
  int mcnt[3];
  int passes[3];

  function automatic int cls_of(int w);
    return int'(sc[2*w +: 2]);
  endfunction

  function automatic bit elig(int w, int block);
    int cl;
    cl = cls_of(w);
    if (!sv[w] || ss[w] || cl == 3) return 1'b0;
    if (mcnt[cl] != 0) return 1'b0;
    if (cl == block) return 1'b0;
    return 1'b1;
  endfunction

  task automatic step(input logic [NW-1:0] v, input logic [NW-1:0] s,
                      input logic [2*NW-1:0] c, input string tag);
    exp_t e;
    int   got[2];
    int   blk;
    @(negedge clk);
    sv = v; ss = s; sc = c;
    e.tag = tag;
    for (int b = 0; b < 3; b++) e.busy[b] = (mcnt[b] != 0);
    blk = -1;
    for (int p = 0; p < 2; p++) begin
      got[p] = -1;
      for (int k = 1; k <= H; k++) begin
        int j;
        int w;
        j = (mptr[p] + k) % H;
        w = 2 * j + p;
        if (got[p] < 0 && elig(w, (p == 1) ? blk : -1)) got[p] = w;
      end
      if (p == 0 && got[0] >= 0) blk = cls_of(got[0]);
    end
    e.vld[0] = (got[0] >= 0);
    e.vld[1] = (got[1] >= 0);
    e.id0    = (got[0] >= 0) ? IDW'(got[0]) : '0;
    e.id1    = (got[1] >= 0) ? IDW'(got[1]) : '0;
    q.push_back(e);
    for (int b = 0; b < 3; b++) begin
      bit hb;
      hb = (got[0] >= 0 && cls_of(got[0]) == b) || (got[1] >= 0 && cls_of(got[1]) == b);
      if (hb) mcnt[b] = passes[b] - 1;
      else if (mcnt[b] > 0) mcnt[b] = mcnt[b] - 1;
    end
    for (int p = 0; p < 2; p++) if (got[p] >= 0) mptr[p] = got[p] / 2;
  endtask

  // Monitor: compares each cycle mid-low-phase
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (gnt_vld !== e.vld || gnt_id0 !== e.id0 || gnt_id1 !== e.id1 ||
            unit_busy !== e.busy) begin
          bad++;
          $display("FAIL %s: vld=%b id0=%0d id1=%0d busy=%b expected vld=%b id0=%0d id1=%0d busy=%b",
                   e.tag, gnt_vld, gnt_id0, gnt_id1, unit_busy,
                   e.vld, e.id0, e.id1, e.busy);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(20 * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [NW-1:0]   tv, ts;
  logic [2*NW-1:0] tc;

  initial begin
    passes[0] = 1; passes[1] = 2; passes[2] = 4;
    mptr[0] = H - 1; mptr[1] = H - 1;
    for (int b = 0; b < 3; b++) mcnt[b] = 0;
    rst_n = 1'b0; sv = '0; ss = '0; sc = '0;
    repeat (3) @(posedge clk);
    #5;
    total++;
    if (unit_busy !== 3'b000 || gnt_vld !== 2'b00) begin
      bad++;
      $display("FAIL R1: busy=%b vld=%b expected busy=000 vld=00", unit_busy, gnt_vld);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step('0, '0, '0, "R1");

    // R1 then R6: all slots ALU, port 1 blocked by port 0
    tv = '1; ts = '0; tc = '0;
    step(tv, ts, tc, "R1");
    step(tv, ts, tc, "R6");
    step(tv, ts, tc, "R6");

    // R3: even ALU, odd load/store, both ports active
    for (int w = 0; w < NW; w++) tc[2*w +: 2] = w[0] ? 2'd1 : 2'd0;
    repeat (6) step(tv, ts, tc, "R3");

    // R4: wrap with only slots 0 and 46
    tv = '0; tv[0] = 1'b1; tv[46] = 1'b1; tc = '0;
    repeat (4) step(tv, ts, tc, "R4");

    // R2: stalls and class code 3
    tv = '1; ts = '0;
    for (int w = 0; w < NW; w++) begin
      if (w[0]) begin
        tc[2*w +: 2] = 2'd1;
        ts[w] = !(w == 9 || w == 15);
      end else begin
        tc[2*w +: 2] = (w == 20) ? 2'd0 : 2'd3;
      end
    end
    ts[20] = 1'b0;
    repeat (6) step(tv, ts, tc, "R2");

    // R5: idle then sparse pool, pointer must hold
    repeat (3) step('0, '0, '0, "R5");
    tv = '0; ts = '0; tc = '0; tv[10] = 1'b1; tv[40] = 1'b1;
    repeat (3) step(tv, ts, tc, "R5");

    // R7: odd slots special function, four-pass occupancy
    tv = '0; tc = '0;
    for (int w = 1; w < NW; w += 2) begin
      tv[w] = 1'b1;
      tc[2*w +: 2] = 2'd2;
    end
    repeat (10) step(tv, ts, tc, "R7");
    repeat (4) step('0, '0, '0, "R7");

    // R8: two special-function requests; odd one waits for the unit
    tv = '0; tc = '0;
    tv[4] = 1'b1; tv[5] = 1'b1;
    tc[2*4 +: 2] = 2'd2; tc[2*5 +: 2] = 2'd2;
    step(tv, ts, tc, "R8");
    tv[4] = 1'b0;
    repeat (5) step(tv, ts, tc, "R8");

    step('0, '0, '0, "R8");
    repeat (3) @(negedge clk);
    #8;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule